// File: doc/BRIEF.md
# Hall-sensor six-step commutation logic

This block turns the three Hall-effect sensor levels of a brushless DC motor into on/off requests for the six switches of a three-phase bridge (one high-side and one low-side switch per phase). The sensor levels pass through a two-flop synchroniser. They are optionally inverted to reverse the direction of rotation. They are then decoded with one of two tables, chosen by the sensor spacing (60 or 120 electrical degrees). For each sensor code, exactly one high-side switch and one low-side switch, in different phases, are requested.

Speed control uses a chopping input, and a select input decides whether chopping acts on the low-side switch only or on both conducting switches. A brake input shorts the windings through the low-side switches. An enable input, an undervoltage flag, an overcurrent-shutdown flag and the detection of impossible sensor codes shut the bridge down. An active-low fault output summarises these shutdown causes. Each phase has its own dead-time counter, so a switch turns on only after both switches of that phase have been off for a set number of clock cycles.

Top module: `hall_commutator`

## Requirements
- R1: With spacing60_i high and fwd_i high, the sensor code {hall_i[2],hall_i[1],hall_i[0]} (phase A in bit 2) decodes as follows. 000 gives high A + low B. 100 gives high A + low C. 110 gives high B + low C. 111 gives high B + low A. 011 gives high C + low A. 001 gives high C + low B. Gate vectors index phase A at bit 0, B at bit 1 and C at bit 2.
- R2: With spacing60_i low and fwd_i high, the decode is as follows. 101 gives high A + low B. 100 gives high A + low C. 110 gives high B + low C. 010 gives high B + low A. 011 gives high C + low A. 001 gives high C + low B.
- R3: With fwd_i low, all three sensor bits are inverted before the R1/R2 decode.
- R4: A code that is invalid for the selected spacing (010 or 101 at 60 degrees, 000 or 111 at 120 degrees, after any inversion) turns all six switches off and drives fault_n_o low, unless brake or undervoltage applies.
- R5: With en_i low and brake_i low, all six switches are off and fault_n_o is low.
- R6: With brake_i high and uv_i low, all high-side switches are off and all low-side switches are on. This holds whatever the state of enable, the sensor code or overcurrent. fault_n_o is high only when en_i is high, the code is valid and oc_i is low.
- R7: uv_i high turns all six switches off and drives fault_n_o low, and it overrides brake.
- R8: oc_i high with brake_i low turns all six switches off and drives fault_n_o low.
- R9: With pwm_i low, the conducting low-side switch is dropped. If qs_bot_only_i is high, the high-side switch stays on. If qs_bot_only_i is low, the high-side switch is dropped too. With pwm_i high, the decoded pair is applied unchanged.
- R10: No phase ever has both of its switches on. At most one high-side switch is on at any time. Outside braking, at most one low-side switch is on.
- R11: A switch turns on only after both switches of its phase have been off for at least DEAD_CYC clock cycles following the last turn-off in that phase. Turn-off takes effect on the next clock edge.
- R12: While rst_n is low, all six gate outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| hall_i | input | 3 | Hall sensor levels, bit 2 = phase A, bit 0 = phase C |
| spacing60_i | input | 1 | 1 = 60-degree sensor table, 0 = 120-degree table |
| fwd_i | input | 1 | 1 = forward, 0 = reverse (sensor bits inverted) |
| en_i | input | 1 | 1 = commutation allowed |
| brake_i | input | 1 | 1 = low-side switches on, high-side off |
| pwm_i | input | 1 | chopping input, held high for full drive |
| qs_bot_only_i | input | 1 | 1 = chop low side only, 0 = chop both |
| uv_i | input | 1 | undervoltage flag |
| oc_i | input | 1 | overcurrent-shutdown flag from the current supervisor |
| top_o | output | 3 | high-side switch enables, bit 0 = phase A |
| bot_o | output | 3 | low-side switch enables, bit 0 = phase A |
| fault_n_o | output | 1 | low while disabled, undervoltage, invalid code or overcurrent |

## Verification
All six valid codes are applied in both directions under both spacing tables. This separates the two decode tables and shows that reversal is a bit inversion rather than a reordering of the steps. The invalid codes of each spacing are applied with the brake released and again with it applied, which separates the shutdown path from the brake path. Brake is also combined with disable, overcurrent and undervoltage, to pin down the priority between them and the exact fault level in each case. Both chopping modes are tried with pwm_i low. Throughout the run, a monitor checks that no phase ever has both switches on and measures the off gap each time a phase swaps sides.

// File: rtl/hc_pkg.sv
package hc_pkg;

    localparam int NPH = 3;

    typedef struct packed {
        logic [NPH-1:0] top;
        logic [NPH-1:0] bot;
    } gates_t;

endpackage

// File: rtl/hc_sync.sv
module hc_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/hc_decode.sv
module hc_decode
    import hc_pkg::*;
(
    input  logic [2:0] code_i,
    input  logic       sp60_i,
    input  logic       fwd_i,
    output gates_t     gates_o,
    output logic       valid_o
);
    logic [2:0] c;
    logic [2:0] step;
    logic [1:0] tix, bix;

    always_comb begin
        c       = fwd_i ? code_i : ~code_i;
        step    = 3'd0;
        valid_o = 1'b1;
        if (sp60_i) begin
            unique case (c)
                3'b000: step = 3'd0;
                3'b100: step = 3'd1;
                3'b110: step = 3'd2;
                3'b111: step = 3'd3;
                3'b011: step = 3'd4;
                3'b001: step = 3'd5;
                default: valid_o = 1'b0;
            endcase
        end else begin
            unique case (c)
                3'b101: step = 3'd0;
                3'b100: step = 3'd1;
                3'b110: step = 3'd2;
                3'b010: step = 3'd3;
                3'b011: step = 3'd4;
                3'b001: step = 3'd5;
                default: valid_o = 1'b0;
            endcase
        end
        // high side advances every two steps, low side leads by one step
        tix = 2'(step >> 1);
        case (3'(step + 3'd1) >> 1)
            3'd0:    bix = 2'd1;
            3'd1:    bix = 2'd2;
            3'd2:    bix = 2'd0;
            default: bix = 2'd1;
        endcase
        gates_o = '0;
        if (valid_o) begin
            gates_o.top[tix] = 1'b1;
            gates_o.bot[bix] = 1'b1;
        end
    end
endmodule

// File: rtl/hc_deadband.sv
module hc_deadband #(
    parameter int DEAD_CYC = 38
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_top_i,
    input  logic req_bot_i,
    output logic top_o,
    output logic bot_o
);
    localparam int CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);

    typedef struct packed {
        logic          top;
        logic          bot;
        logic [CW-1:0] cnt;
    } db_t;

    db_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - CW'(1);
        if (st_q.top && !req_top_i) begin
            st_d.top = 1'b0;
            st_d.cnt = CW'(DEAD_CYC);
        end
        if (st_q.bot && !req_bot_i) begin
            st_d.bot = 1'b0;
            st_d.cnt = CW'(DEAD_CYC);
        end
        if (!st_q.top && !st_q.bot && st_q.cnt == '0) begin
            if (req_top_i && !req_bot_i) st_d.top = 1'b1;
            if (req_bot_i && !req_top_i) st_d.bot = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign top_o = st_q.top;
    assign bot_o = st_q.bot;

    // R10: never both switches of this phase
    a_r10_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.top && st_q.bot));
    // R11: turn-on only after the gap has run out with the partner off
    a_r11_top_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.top) |-> ($past(st_q.cnt) == '0 && !$past(st_q.bot)));
    a_r11_bot_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.bot) |-> ($past(st_q.cnt) == '0 && !$past(st_q.top)));
    a_r11_fast_off: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.top && !req_top_i) |=> !st_q.top);
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hc_pkg::*;
#(
    parameter int DEAD_CYC = 38
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_i,
    input  logic       spacing60_i,
    input  logic       fwd_i,
    input  logic       en_i,
    input  logic       brake_i,
    input  logic       pwm_i,
    input  logic       qs_bot_only_i,
    input  logic       uv_i,
    input  logic       oc_i,
    output logic [2:0] top_o,
    output logic [2:0] bot_o,
    output logic       fault_n_o
);
    logic [2:0] hall_s;
    gates_t     dec, req;
    logic       valid;

    hc_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (hall_i),
        .q_o   (hall_s)
    );

    hc_decode u_dec (
        .code_i  (hall_s),
        .sp60_i  (spacing60_i),
        .fwd_i   (fwd_i),
        .gates_o (dec),
        .valid_o (valid)
    );

    always_comb begin
        req = '0;
        if (uv_i) begin
            req = '0;
        end else if (brake_i) begin
            req.bot = '1;
        end else if (en_i && valid && !oc_i) begin
            req.top = dec.top & {NPH{qs_bot_only_i | pwm_i}};
            req.bot = dec.bot & {NPH{pwm_i}};
        end
    end

    assign fault_n_o = ~(~en_i | uv_i | ~valid | oc_i);

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        hc_deadband #(.DEAD_CYC(DEAD_CYC)) u_db (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_top_i (req.top[p]),
            .req_bot_i (req.bot[p]),
            .top_o     (top_o[p]),
            .bot_o     (bot_o[p])
        );
    end

    // R10: one high-side switch at most
    a_r10_top_one: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(top_o));
    // R10: one low-side switch at most outside braking
    a_r10_bot_one: assert property (@(posedge clk) disable iff (!rst_n)
        !brake_i |=> $onehot0(bot_o));
    // R7: undervoltage drops every switch on the next edge
    a_r7_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |=> (top_o == 3'b000 && bot_o == 3'b000));
    // R6: braking clears the high side on the next edge
    a_r6_brake_top: assert property (@(posedge clk) disable iff (!rst_n)
        (brake_i && !uv_i) |=> top_o == 3'b000);
    // R4: an invalid code without brake drops every switch
    a_r4_invalid_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !brake_i) |=> (top_o == 3'b000 && bot_o == 3'b000));
    // R5: disable always shows as a fault
    a_r5_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !fault_n_o);
endmodule

// File: tb/tb_hall_commutator.sv
module tb_hall_commutator;
    localparam int DEAD   = 38;
    localparam int SETTLE = DEAD + 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall = 3'b000;
    logic       sp60 = 1'b1, fwd = 1'b1, en = 1'b1, brk = 1'b0;
    logic       pwm = 1'b1, qs = 1'b1, uv = 1'b0, oc = 1'b0;
    logic [2:0] top_o, bot_o;
    logic       fault_n;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [6:0] exp;   // {top[2:0], bot[2:0], fault_n}
        string      tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    hall_commutator #(.DEAD_CYC(DEAD)) dut (
        .clk(clk), .rst_n(rst_n), .hall_i(hall), .spacing60_i(sp60),
        .fwd_i(fwd), .en_i(en), .brake_i(brk), .pwm_i(pwm),
        .qs_bot_only_i(qs), .uv_i(uv), .oc_i(oc),
        .top_o(top_o), .bot_o(bot_o), .fault_n_o(fault_n)
    );

    function automatic logic [6:0] model(logic [2:0] h, logic s60, logic f,
        logic e, logic b, logic p, logic q, logic u, logic o);
        logic [2:0] c, t, bo;
        logic v, fl;
        c  = f ? h : ~h;
        t  = 3'b000;
        bo = 3'b000;
        v  = 1'b1;
        if (s60) begin
            case (c)
                3'b000: begin t = 3'b001; bo = 3'b010; end
                3'b100: begin t = 3'b001; bo = 3'b100; end
                3'b110: begin t = 3'b010; bo = 3'b100; end
                3'b111: begin t = 3'b010; bo = 3'b001; end
                3'b011: begin t = 3'b100; bo = 3'b001; end
                3'b001: begin t = 3'b100; bo = 3'b010; end
                default: v = 1'b0;
            endcase
        end else begin
            case (c)
                3'b101: begin t = 3'b001; bo = 3'b010; end
                3'b100: begin t = 3'b001; bo = 3'b100; end
                3'b110: begin t = 3'b010; bo = 3'b100; end
                3'b010: begin t = 3'b010; bo = 3'b001; end
                3'b011: begin t = 3'b100; bo = 3'b001; end
                3'b001: begin t = 3'b100; bo = 3'b010; end
                default: v = 1'b0;
            endcase
        end
        fl = !u && e && v && !o;
        if (u) begin
            t = 3'b000; bo = 3'b000;
        end else if (b) begin
            t = 3'b000; bo = 3'b111;
        end else if (!e || !v || o) begin
            t = 3'b000; bo = 3'b000;
        end else begin
            if (!p) bo = 3'b000;
            if (!p && !q) t = 3'b000;
        end
        return {t, bo, fl};
    endfunction

    task automatic apply(input logic [2:0] h, input logic s60, input logic f,
        input logic e, input logic b, input logic p, input logic q,
        input logic u, input logic o, input string tag);
        item_t it;
        @(negedge clk);
        hall = h; sp60 = s60; fwd = f; en = e; brk = b;
        pwm = p; qs = q; uv = u; oc = o;
        repeat (SETTLE) @(posedge clk);
        it.exp = model(h, s60, f, e, b, p, q, u, o);
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [6:0] act;
                it  = sb.pop_front();
                act = {top_o, bot_o, fault_n};
                vectors++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got top=%b bot=%b fault_n=%b, expected top=%b bot=%b fault_n=%b",
                        it.tag, act[6:4], act[3:1], act[0], it.exp[6:4], it.exp[3:1], it.exp[0]);
                end
            end
        end
    end

    // R10 / R11 phase monitor
    int shoot = 0;
    int offrun[3];
    int lastside[3];
    logic [2:0] ptop = 3'b000, pbot = 3'b000;
    initial begin
        for (int p = 0; p < 3; p++) begin offrun[p] = 0; lastside[p] = 0; end
        forever begin
            @(negedge clk);
            if (rst_n) begin
                for (int p = 0; p < 3; p++) begin
                    if (top_o[p] && bot_o[p]) shoot++;
                    if ((top_o[p] && !ptop[p] && lastside[p] == 2) ||
                        (bot_o[p] && !pbot[p] && lastside[p] == 1)) begin
                        vectors++;
                        if (offrun[p] < DEAD) begin
                            errors++;
                            $display("FAIL R11 phase %0d gap: got %0d cycles, expected >= %0d",
                                p, offrun[p], DEAD);
                        end
                    end
                    if (top_o[p]) lastside[p] = 1;
                    if (bot_o[p]) lastside[p] = 2;
                    if (!top_o[p] && !bot_o[p]) offrun[p]++;
                    else offrun[p] = 0;
                end
                ptop = top_o;
                pbot = bot_o;
            end
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: got timeout, expected run to finish");
            summary();
        end
    end

    initial begin
        logic [2:0] seq60 [6];
        logic [2:0] seq120 [6];
        seq60  = '{3'b000, 3'b100, 3'b110, 3'b111, 3'b011, 3'b001};
        seq120 = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};

        // R12: reset holds gates low
        repeat (5) @(negedge clk);
        vectors++;
        if (top_o !== 3'b000 || bot_o !== 3'b000) begin
            errors++;
            $display("FAIL R12 reset: got top=%b bot=%b, expected 000 000", top_o, bot_o);
        end
        rst_n = 1'b1;

        // R1 / R3: 60-degree table, forward then reverse
        for (int i = 0; i < 6; i++)
            apply(seq60[i], 1, 1, 1, 0, 1, 1, 0, 0, "R1 60deg forward");
        for (int i = 5; i >= 0; i--)
            apply(seq60[i], 1, 0, 1, 0, 1, 1, 0, 0, "R3 60deg reverse");
        // R2 / R3: 120-degree table
        for (int i = 0; i < 6; i++)
            apply(seq120[i], 0, 1, 1, 0, 1, 1, 0, 0, "R2 120deg forward");
        for (int i = 5; i >= 0; i--)
            apply(seq120[i], 0, 0, 1, 0, 1, 1, 0, 0, "R3 120deg reverse");

        // R4: invalid codes for each spacing
        apply(3'b010, 1, 1, 1, 0, 1, 1, 0, 0, "R4 invalid 010 at 60");
        apply(3'b101, 1, 0, 1, 0, 1, 1, 0, 0, "R4 invalid 101 at 60 reverse");
        apply(3'b000, 0, 1, 1, 0, 1, 1, 0, 0, "R4 invalid 000 at 120");
        apply(3'b111, 0, 1, 1, 0, 1, 1, 0, 0, "R4 invalid 111 at 120");

        // R5: disable
        apply(3'b100, 1, 1, 0, 0, 1, 1, 0, 0, "R5 disabled");
        apply(3'b100, 1, 1, 1, 0, 1, 1, 0, 0, "R5 re-enabled");

        // R6: brake variants
        apply(3'b100, 1, 1, 1, 1, 1, 1, 0, 0, "R6 normal brake");
        apply(3'b100, 1, 1, 0, 1, 1, 1, 0, 0, "R6 brake while disabled");
        apply(3'b010, 1, 1, 1, 1, 1, 1, 0, 0, "R6 brake invalid code");
        apply(3'b100, 1, 1, 1, 1, 1, 1, 0, 1, "R6 brake with overcurrent");
        apply(3'b110, 1, 1, 1, 0, 1, 1, 0, 0, "R6 brake released");

        // R7: undervoltage, including over brake
        apply(3'b110, 1, 1, 1, 0, 1, 1, 1, 0, "R7 undervoltage");
        apply(3'b110, 1, 1, 1, 1, 1, 1, 1, 0, "R7 undervoltage over brake");

        // R8: overcurrent
        apply(3'b110, 1, 1, 1, 0, 1, 1, 0, 0, "R8 before overcurrent");
        apply(3'b110, 1, 1, 1, 0, 1, 1, 0, 1, "R8 overcurrent");

        // R9: chopping modes
        apply(3'b011, 1, 1, 1, 0, 1, 1, 0, 0, "R9 pwm high");
        apply(3'b011, 1, 1, 1, 0, 0, 1, 0, 0, "R9 pwm low bottom only");
        apply(3'b011, 1, 1, 1, 0, 0, 0, 0, 0, "R9 pwm low both banks");
        apply(3'b011, 1, 1, 1, 0, 1, 0, 0, 0, "R9 pwm high both banks");

        // R10: shoot-through count over the whole run
        vectors++;
        if (shoot != 0) begin
            errors++;
            $display("FAIL R10 no phase both on: got %0d cycles, expected 0", shoot);
        end

        done = 1'b1;
        summary();
    end
endmodule